// File: doc/BRIEF.md
# Software Write-Protect Unlock Sequencer

This block sits between the host write strobes of a paged non-volatile memory and its page load controller. It watches every qualified host write as an address/data event. It lets data through to the page buffer only after a fixed three-write command sequence has unlocked it. Protection is always on. The sequence must be repeated before every programming cycle, and it re-arms by itself when the memory finishes programming.

The command writes are consumed by the sequencer and never reach the page buffer. Their addresses remain ordinary data locations once the block is unlocked. A write that arrives without the sequence writes nothing. Instead it raises a one-cycle dummy-start pulse, so that the programming timer can present a busy interval with no array change. A write that breaks the sequence part way has the same effect and returns the sequencer to its start. While the memory reports busy, the sequencer ignores all writes and holds its start state.

A host write is a strobe during which chip enable and write enable are both low. It counts only if it is wide enough and stays clean. The address is taken on the first qualifying cycle and the data on the last one.

Top module: `wp_unlock_seq`

## Requirements
- R1: After reset, `load_en` and `dummy_start` are low, `ld_addr` is 0 and `ld_data` is 0.
- R2: A strobe (`ce_n` and `we_n` both low) held for fewer than `MIN_PULSE` sampled clock cycles is not a write and produces no pulse. One held for `MIN_PULSE` or more cycles produces exactly one event, two cycles after the first cycle in which the strobe is seen released.
- R3: In the locked state, a write that is not data 0xAA at address 0x5555 raises `dummy_start` for one cycle and never `load_en`. Data 0xAA at 0x5555 raises neither pulse.
- R4: The sequence 0xAA@0x5555, 0x55@0x2AAA, 0xA0@0x5555 produces no pulse. Every later write then raises `load_en` for one cycle, with `ld_addr`/`ld_data` equal to that write's address and data. `ld_addr` and `ld_data` change only together with `load_en`.
- R5: Command addresses are compared on address bits 14..0 only. Bits 16..15 do not affect matching, but they are passed unchanged on `ld_addr`.
- R6: A write that does not match the expected second or third command step raises `dummy_start` once and returns to the locked state. A fresh full sequence then unlocks again.
- R7: Once unlocked, writes whose address and data equal a command step are loaded as ordinary data.
- R8: While `prog_busy` is high, writes raise no pulse, and the unlocked state is discarded. After `prog_busy` falls, a write without a new sequence gives `dummy_start` and no `load_en`.
- R9: A strobe during which `oe_n` is low or `wr_inhibit` is high in any cycle is not a write and raises no pulse. This holds in both the locked and the unlocked state.
- R10: `load_en` and `dummy_start` are never high in the same cycle, and `load_en` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low, sampled |
| oe_n | input | 1 | Output enable, active low; low blocks writes |
| we_n | input | 1 | Write enable, active low, sampled |
| wr_inhibit | input | 1 | Hardware write inhibit, high blocks writes |
| prog_busy | input | 1 | Memory is programming; sequencer held idle |
| addr | input | ADDR_W | Host address |
| data | input | DATA_W | Host write data |
| load_en | output | 1 | One-cycle page-load strobe |
| ld_addr | output | ADDR_W | Address of the loaded byte |
| ld_data | output | DATA_W | Data of the loaded byte |
| dummy_start | output | 1 | One-cycle start of a no-write busy interval |

## Verification
The assertions check, on every cycle, the output-side rules:
- the two pulses never coincide, and a load never repeats back to back;
- every pulse follows a released strobe, and no pulse follows a busy cycle;
- the load address and data move only with a load.

Only the bench scenarios can show that the sequencer responds to the right values: the exact command bytes and their order, the 15-bit address compare, the width threshold of the strobe qualifier, the abort on output enable or inhibit, and the re-arming after a busy interval. They do this by sweeping every data value at the first and second command steps and every strobe width around the threshold.

// File: rtl/wp_unlock_pkg.sv
package wp_unlock_pkg;

   // Sequencer position: locked and waiting for a step, or unlocked.
   typedef enum logic [1:0] {
      WP_LOCKED = 2'd0,
      WP_STEP1  = 2'd1,
      WP_STEP2  = 2'd2,
      WP_OPEN   = 2'd3
   } wp_state_e;

   localparam int WP_STEPS = 3;

   // Default command values; the address is compared on the low bits only.
   localparam logic [14:0] WP_DEF_ADDR_A = 15'h5555;
   localparam logic [14:0] WP_DEF_ADDR_B = 15'h2AAA;
   localparam logic [7:0]  WP_DEF_DATA_0 = 8'hAA;
   localparam logic [7:0]  WP_DEF_DATA_1 = 8'h55;
   localparam logic [7:0]  WP_DEF_DATA_2 = 8'hA0;

endpackage

// File: rtl/wp_strobe_qual.sv
// Turns raw sampled strobes into single-cycle write events.
module wp_strobe_qual #(
   parameter int ADDR_W    = 17,
   parameter int DATA_W    = 8,
   parameter int MIN_PULSE = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic              wr_inhibit,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic              evt,
   output logic [ADDR_W-1:0] evt_addr,
   output logic [DATA_W-1:0] evt_data
);

   logic strobe;
   logic enabled;
   logic aborted_q;
   logic step_en;
   logic first_cyc;
   logic wide_enough;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;

   assign strobe  = !ce_n && !we_n;
   assign enabled = oe_n && !wr_inhibit;
   assign step_en = strobe && enabled && !aborted_q;

   generate
      if (MIN_PULSE == 1) begin : g_flag
         // A single qualifying cycle is enough: a seen-flag replaces the counter.
         logic seen_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               seen_q <= 1'b0;
            end else if (!strobe) begin
               seen_q <= 1'b0;
            end else if (step_en) begin
               seen_q <= 1'b1;
            end
         end
         assign first_cyc   = !seen_q;
         assign wide_enough = seen_q;
      end else begin : g_count
         localparam int CNT_W = $clog2(MIN_PULSE + 1);
         localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MIN_PULSE);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!strobe) begin
               cnt_q <= '0;
            end else if (step_en && (cnt_q != CNT_SAT)) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         assign first_cyc   = (cnt_q == '0);
         assign wide_enough = (cnt_q == CNT_SAT);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aborted_q <= 1'b0;
         addr_q    <= '0;
         data_q    <= '0;
         evt       <= 1'b0;
         evt_addr  <= '0;
         evt_data  <= '0;
      end else begin
         evt <= 1'b0;
         if (strobe) begin
            if (!enabled) begin
               aborted_q <= 1'b1;
            end else if (!aborted_q) begin
               if (first_cyc) begin
                  addr_q <= addr;
               end
               data_q <= data;
            end
         end else begin
            evt       <= wide_enough && !aborted_q;
            evt_addr  <= addr_q;
            evt_data  <= data_q;
            aborted_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/wp_cmd_match.sv
// Compares a write event with each command step of the unlock sequence.
module wp_cmd_match #(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8,
   parameter int CMP_W  = 15,
   parameter logic [CMP_W-1:0]  ADDR_A = '0,
   parameter logic [CMP_W-1:0]  ADDR_B = '0,
   parameter logic [DATA_W-1:0] DATA_0 = '0,
   parameter logic [DATA_W-1:0] DATA_1 = '0,
   parameter logic [DATA_W-1:0] DATA_2 = '0
) (
   input  logic [ADDR_W-1:0] evt_addr,
   input  logic [DATA_W-1:0] evt_data,
   output logic [wp_unlock_pkg::WP_STEPS-1:0] hit
);

   localparam int NSTEP = wp_unlock_pkg::WP_STEPS;

   function automatic logic [CMP_W-1:0] step_addr(input int idx);
      return (idx == 1) ? ADDR_B : ADDR_A;
   endfunction

   function automatic logic [DATA_W-1:0] step_data(input int idx);
      case (idx)
         0:       return DATA_0;
         1:       return DATA_1;
         default: return DATA_2;
      endcase
   endfunction

   logic [CMP_W-1:0] low_addr;
   assign low_addr = evt_addr[CMP_W-1:0];

   generate
      for (genvar s = 0; s < NSTEP; s++) begin : g_step
         assign hit[s] = (low_addr == step_addr(s)) && (evt_data == step_data(s));
      end
   endgenerate

endmodule

// File: rtl/wp_seq_fsm.sv
// Unlock state machine and output pulse registers.
module wp_seq_fsm #(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt,
   input  logic [ADDR_W-1:0] evt_addr,
   input  logic [DATA_W-1:0] evt_data,
   input  logic [wp_unlock_pkg::WP_STEPS-1:0] hit,
   input  logic              prog_busy,
   output logic              load_en,
   output logic [ADDR_W-1:0] ld_addr,
   output logic [DATA_W-1:0] ld_data,
   output logic              dummy_start
);

   import wp_unlock_pkg::*;

   wp_state_e state_q, state_d;
   logic      load_d;
   logic      dummy_d;
   logic      step_hit;

   always_comb begin
      case (state_q)
         WP_LOCKED: step_hit = hit[0];
         WP_STEP1:  step_hit = hit[1];
         WP_STEP2:  step_hit = hit[2];
         default:   step_hit = 1'b0;
      endcase
   end

   always_comb begin
      state_d = state_q;
      load_d  = 1'b0;
      dummy_d = 1'b0;
      if (prog_busy) begin
         state_d = WP_LOCKED;
      end else if (evt) begin
         if (state_q == WP_OPEN) begin
            load_d = 1'b1;
         end else if (step_hit) begin
            case (state_q)
               WP_LOCKED: state_d = WP_STEP1;
               WP_STEP1:  state_d = WP_STEP2;
               default:   state_d = WP_OPEN;
            endcase
         end else begin
            state_d = WP_LOCKED;
            dummy_d = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= WP_LOCKED;
         load_en     <= 1'b0;
         dummy_start <= 1'b0;
         ld_addr     <= '0;
         ld_data     <= '0;
      end else begin
         state_q     <= state_d;
         load_en     <= load_d;
         dummy_start <= dummy_d;
         if (load_d) begin
            ld_addr <= evt_addr;
            ld_data <= evt_data;
         end
      end
   end

endmodule

// File: rtl/wp_unlock_seq.sv
module wp_unlock_seq #(
   parameter int ADDR_W    = 17,
   parameter int DATA_W    = 8,
   parameter int CMP_W     = 15,
   parameter int MIN_PULSE = 3,
   parameter logic [CMP_W-1:0]  ADDR_A = wp_unlock_pkg::WP_DEF_ADDR_A,
   parameter logic [CMP_W-1:0]  ADDR_B = wp_unlock_pkg::WP_DEF_ADDR_B,
   parameter logic [DATA_W-1:0] DATA_0 = wp_unlock_pkg::WP_DEF_DATA_0,
   parameter logic [DATA_W-1:0] DATA_1 = wp_unlock_pkg::WP_DEF_DATA_1,
   parameter logic [DATA_W-1:0] DATA_2 = wp_unlock_pkg::WP_DEF_DATA_2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              wr_inhibit,
   input  logic              prog_busy,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic              load_en,
   output logic [ADDR_W-1:0] ld_addr,
   output logic [DATA_W-1:0] ld_data,
   output logic              dummy_start
);

   localparam int NSTEP = wp_unlock_pkg::WP_STEPS;

   generate
      if (CMP_W < 1 || CMP_W > ADDR_W) begin : g_bad_cmp
         $error("wp_unlock_seq: CMP_W must lie in 1..ADDR_W");
      end
      if (MIN_PULSE < 1) begin : g_bad_pulse
         $error("wp_unlock_seq: MIN_PULSE must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("wp_unlock_seq: DATA_W must be at least 1");
      end
   endgenerate

   logic              evt;
   logic [ADDR_W-1:0] evt_addr;
   logic [DATA_W-1:0] evt_data;
   logic [NSTEP-1:0]  hit;

   wp_strobe_qual #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .MIN_PULSE (MIN_PULSE)
   ) u_qual (
      .clk        (clk),
      .rst_n      (rst_n),
      .ce_n       (ce_n),
      .we_n       (we_n),
      .oe_n       (oe_n),
      .wr_inhibit (wr_inhibit),
      .addr       (addr),
      .data       (data),
      .evt        (evt),
      .evt_addr   (evt_addr),
      .evt_data   (evt_data)
   );

   wp_cmd_match #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CMP_W  (CMP_W),
      .ADDR_A (ADDR_A),
      .ADDR_B (ADDR_B),
      .DATA_0 (DATA_0),
      .DATA_1 (DATA_1),
      .DATA_2 (DATA_2)
   ) u_match (
      .evt_addr (evt_addr),
      .evt_data (evt_data),
      .hit      (hit)
   );

   wp_seq_fsm #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt         (evt),
      .evt_addr    (evt_addr),
      .evt_data    (evt_data),
      .hit         (hit),
      .prog_busy   (prog_busy),
      .load_en     (load_en),
      .ld_addr     (ld_addr),
      .ld_data     (ld_data),
      .dummy_start (dummy_start)
   );

endmodule

// File: rtl/wp_unlock_seq_chk.sv
module wp_unlock_seq_chk #(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              we_n,
   input logic              prog_busy,
   input logic              load_en,
   input logic [ADDR_W-1:0] ld_addr,
   input logic [DATA_W-1:0] ld_data,
   input logic              dummy_start
);

   // R10: the two output pulses are exclusive
   a_r10_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_en && dummy_start));

   // R4: a load lasts exactly one cycle
   a_r4_load_single: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> !load_en);

   // R4: load address and data move only with a load
   a_r4_ld_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(ld_addr) || !$stable(ld_data)) |-> load_en);

   // R2: every pulse follows a cycle in which the strobe was released
   a_r2_after_release: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en || dummy_start) |-> $past(ce_n || we_n, 2));

   // R8: no pulse right after a busy cycle
   a_r8_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
      prog_busy |=> (!load_en && !dummy_start));

endmodule

bind wp_unlock_seq wp_unlock_seq_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ce_n        (ce_n),
   .we_n        (we_n),
   .prog_busy   (prog_busy),
   .load_en     (load_en),
   .ld_addr     (ld_addr),
   .ld_data     (ld_data),
   .dummy_start (dummy_start)
);

// File: tb/wp_unlock_seq_tb.sv
`timescale 1ns/1ps
module wp_unlock_seq_tb;

   localparam int AW   = 17;
   localparam int DW   = 8;
   localparam int MINP = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic wr_inhibit = 1'b0, prog_busy = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] data = '0;
   logic load_en, dummy_start;
   logic [AW-1:0] ld_addr;
   logic [DW-1:0] ld_data;

   int n_checks = 0;
   int n_fail   = 0;
   int n_load   = 0;
   int n_dummy  = 0;
   logic [AW-1:0] last_a = '0;
   logic [DW-1:0] last_d = '0;
   bit done = 0;

   always #5 clk = ~clk;

   wp_unlock_seq #(.ADDR_W(AW), .DATA_W(DW), .CMP_W(15), .MIN_PULSE(MINP)) u_dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .wr_inhibit(wr_inhibit), .prog_busy(prog_busy), .addr(addr), .data(data),
      .load_en(load_en), .ld_addr(ld_addr), .ld_data(ld_data),
      .dummy_start(dummy_start)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (load_en) begin
            n_load++;
            last_a = ld_addr;
            last_d = ld_data;
         end
         if (dummy_start) n_dummy++;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input int w,
                     input bit oe_lo, input bit inh);
      @(negedge clk);
      addr = a; data = d; ce_n = 1'b0; we_n = 1'b0;
      oe_n = !oe_lo; wr_inhibit = inh;
      repeat (w) @(negedge clk);
      ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; wr_inhibit = 1'b0;
      addr = '0; data = '0;
      repeat (4) @(negedge clk);
   endtask

   // Write and compare the pulse counts it caused.
   task automatic wr_chk(input logic [AW-1:0] a, input logic [DW-1:0] d, input int w,
                         input bit oe_lo, input bit inh, input int exp_ld,
                         input int exp_dm, input string req);
      int l0, d0;
      l0 = n_load; d0 = n_dummy;
      wr(a, d, w, oe_lo, inh);
      chk((n_load - l0) == exp_ld, {req, " load count"}, n_load - l0, exp_ld);
      chk((n_dummy - d0) == exp_dm, {req, " dummy count"}, n_dummy - d0, exp_dm);
      if (exp_ld == 1) begin
         chk(last_a == a, {req, " load addr"}, last_a, a);
         chk(last_d == d, {req, " load data"}, last_d, d);
      end
   endtask

   task automatic rearm();
      @(negedge clk); prog_busy = 1'b1;
      repeat (3) @(negedge clk);
      prog_busy = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic unlock(input logic [1:0] hi0, input logic [1:0] hi1, input logic [1:0] hi2,
                         input string req);
      wr_chk({hi0, 15'h5555}, 8'hAA, MINP, 0, 0, 0, 0, req);
      wr_chk({hi1, 15'h2AAA}, 8'h55, MINP, 0, 0, 0, 0, req);
      wr_chk({hi2, 15'h5555}, 8'hA0, MINP, 0, 0, 0, 0, req);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(load_en == 1'b0, "R1 load_en", load_en, 0);
      chk(dummy_start == 1'b0, "R1 dummy_start", dummy_start, 0);
      chk(ld_addr == '0, "R1 ld_addr", ld_addr, 0);
      chk(ld_data == '0, "R1 ld_data", ld_data, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2: strobe width sweep around the threshold, unprotected write
      for (int w = 1; w <= MINP + 3; w++) begin
         wr_chk(17'h00100, 8'h11, w, 0, 0, 0, (w >= MINP) ? 1 : 0, "R2");
      end

      // R3: every data value at the first command address
      for (int d = 0; d < 256; d++) begin
         wr_chk({2'b00, 15'h5555}, DW'(d), MINP, 0, 0, 0, (d == 8'hAA) ? 0 : 1, "R3");
         rearm();
      end
      wr_chk(17'h05554, 8'hAA, MINP, 0, 0, 0, 1, "R3 wrong address");

      // R4: unlock, then a page of loads
      unlock(2'b00, 2'b00, 2'b00, "R4 command");
      for (int i = 0; i < 8; i++) begin
         wr_chk(AW'(17'h01200 + i * 5), DW'(8'h30 + i * 7), MINP, 0, 0, 1, 0, "R4 data");
      end
      // R7: command look-alikes are data once unlocked
      wr_chk(17'h05555, 8'hAA, MINP, 0, 0, 1, 0, "R7 aa");
      wr_chk(17'h02AAA, 8'h55, MINP, 0, 0, 1, 0, "R7 55");
      wr_chk(17'h05555, 8'hA0, MINP, 0, 0, 1, 0, "R7 a0");

      // R9: blocked strobes while unlocked, then a normal load
      wr_chk(17'h00321, 8'h9C, MINP + 1, 1, 0, 0, 0, "R9 oe low");
      wr_chk(17'h00322, 8'h9D, MINP + 1, 0, 1, 0, 0, "R9 inhibit");
      wr_chk(17'h00323, 8'h9E, MINP, 0, 0, 1, 0, "R9 after block");

      // R8: busy discards the unlocked state and mutes writes
      @(negedge clk); prog_busy = 1'b1;
      wr_chk(17'h00400, 8'h42, MINP, 0, 0, 0, 0, "R8 during busy");
      prog_busy = 1'b0;
      repeat (2) @(negedge clk);
      wr_chk(17'h00401, 8'h43, MINP, 0, 0, 0, 1, "R8 after busy");

      // R9: blocked strobes while locked give no dummy either
      wr_chk(17'h00500, 8'h01, MINP, 1, 0, 0, 0, "R9 locked oe low");
      wr_chk(17'h00500, 8'h01, MINP, 0, 1, 0, 0, "R9 locked inhibit");

      // R5: upper address bits ignored in the compare, passed on the load
      unlock(2'b11, 2'b10, 2'b01, "R5 command");
      wr_chk(17'h1ABCD, 8'h3C, MINP, 0, 0, 1, 0, "R5 data");
      rearm();

      // R6: every data value at the second step
      for (int d = 0; d < 256; d++) begin
         wr_chk(17'h05555, 8'hAA, MINP, 0, 0, 0, 0, "R6 step1");
         wr_chk(17'h02AAA, DW'(d), MINP, 0, 0, 0, (d == 8'h55) ? 0 : 1, "R6 step2");
         rearm();
      end
      // R6: deviations at the third step and on an address
      wr_chk(17'h05555, 8'hAA, MINP, 0, 0, 0, 0, "R6 s1");
      wr_chk(17'h02AAA, 8'h55, MINP, 0, 0, 0, 0, "R6 s2");
      wr_chk(17'h05555, 8'hA1, MINP, 0, 0, 0, 1, "R6 step3 data");
      wr_chk(17'h00777, 8'h77, MINP, 0, 0, 0, 1, "R6 back to locked");
      wr_chk(17'h05555, 8'hAA, MINP, 0, 0, 0, 0, "R6 s1b");
      wr_chk(17'h02AAB, 8'h55, MINP, 0, 0, 0, 1, "R6 step2 addr");
      unlock(2'b00, 2'b00, 2'b00, "R6 fresh");
      wr_chk(17'h00888, 8'h88, MINP, 0, 0, 1, 0, "R6 fresh load");

      // R10: a load pulse is a single cycle (bench view)
      begin
         int l0;
         l0 = n_load;
         wr(17'h00999, 8'h99, MINP, 0, 0);
         chk((n_load - l0) == 1, "R10 single load", n_load - l0, 1);
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL R1 watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule